// File: doc/BRIEF.md
# PWM Event Output Conditioner

The block picks one signal out of a set of PWM generators and turns it into a conditioned event. A 16-bit control word, written through a simple write port, chooses the generator with a 3-bit index and chooses which of its raw signals to use with a 4-bit code. Code zero takes the generator's trigger-select fallback input. Codes one to nine take one line of the generator's signal bundle. The remaining codes are reserved and give a quiet event. A generator whose present flag is low never produces an event.

The chosen signal can be resynchronized through two flops or passed straight on. It can then be widened so that every rising edge yields at least a minimum number of clock cycles of activity. The result is the internal event, which is always active-high. For the pin, that event can be inverted. When the pin is not enabled, the pin is held at the inactive level for the chosen polarity.

Top module: `pwm_evt_cond`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, the control word is all zeros, and `evt_o` and `pin_o` are 0.
- R2: Signal code 0 (control bits 7:4) routes `gen_trg_i[g]` to the event, where g is the generator index in control bits 2:0.
- R3: Signal codes 1 to 9 route bundle line `gen_sig_i[g*9 + code - 1]` of generator g to the event.
- R4: Signal codes 10 to 15 give a constant inactive event (0), whatever the generator inputs are.
- R5: When `gen_present_i[g]` is 0 for the selected generator g, the event is 0.
- R6: With the sync bit (control bit 12) set to 1, the event follows the selected signal with two cycles of delay.
- R7: With the sync bit set to 0, the event follows the selected signal in the same cycle.
- R8: With the stretch-disable bit (control bit 13) set to 0, a rising edge of the signal entering the stretcher holds `evt_o` at 1 for at least 8 cycles, counting the edge cycle. A new rising edge restarts the count. The output stays at 1 while the input stays high.
- R9: With the stretch-disable bit set to 1, `evt_o` has the same width as the signal entering the stretcher.
- R10: With the pin enable bit (control bit 15) set to 1, `pin_o` equals `evt_o` when the polarity bit (control bit 14) is 0, and equals its inverse when the polarity bit is 1.
- R11: With the pin enable bit set to 0, `pin_o` equals the polarity bit (the inactive level), and `evt_o` is not affected.
- R12: A control word that is written while `cfg_we_i` is high at a rising clock edge takes effect from that edge on, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 16 | Control word write data |
| gen_sig_i | input | NUM_GEN*NUM_SIG | Raw generator signal bundles; generator g uses bits g*NUM_SIG and up |
| gen_present_i | input | NUM_GEN | Present flag for each generator |
| gen_trg_i | input | NUM_GEN | Trigger-select fallback source for each generator |
| evt_o | output | 1 | Internal event, active-high |
| pin_o | output | 1 | Event pin level |

## Verification
The random part of the bench drives sparse pulses on every bundle line and on every fallback input. It also drops present flags at random and rewrites random control words. Any routing error (wrong generator, wrong line, or a leak through reserved codes or absent generators) therefore shows up as a mismatch against the bench's own selection function.

Random control words also switch between the sync path and the direct path, and between stretched and unstretched output. This exposes faults in the latency and in the edge-to-edge stretch count, including what happens when the mode changes mid-pulse.

The directed cases do three things. They isolate a single-cycle pulse, to measure the minimum width. They send a retrigger inside an active stretch, to show that the count restarts instead of running out. They perform a write, to show the cycle in which new settings apply.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;
  localparam int CFG_W    = 16;
  localparam int CODE_W   = 4;
  localparam int GIDX_W   = 3;
  localparam int B_OEN    = 15;
  localparam int B_POL    = 14;
  localparam int B_NOSTR  = 13;
  localparam int B_SYNC   = 12;
  localparam int CODE_LSB = 4;
  localparam int GIDX_LSB = 0;

  typedef struct packed {
    logic              oen;
    logic              pol;
    logic              nostr;
    logic              sync;
    logic [CODE_W-1:0] code;
    logic [GIDX_W-1:0] gidx;
  } evt_cfg_t;

  localparam logic [CODE_W-1:0] CODE_FALLBACK = '0;
endpackage

// File: rtl/evt_select.sv
module evt_select import pwm_evt_pkg::*; #(
  parameter int NUM_GEN = 8,
  parameter int NUM_SIG = 9
) (
  input  logic [NUM_GEN*NUM_SIG-1:0] sig_i,
  input  logic [NUM_GEN-1:0]         present_i,
  input  logic [NUM_GEN-1:0]         trg_i,
  input  logic [GIDX_W-1:0]          gidx_i,
  input  logic [CODE_W-1:0]          code_i,
  output logic                       sel_o
);
  logic [NUM_SIG-1:0] bundle [NUM_GEN];

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_bundle
    assign bundle[g] = sig_i[g*NUM_SIG +: NUM_SIG];
  end

  logic [CODE_W-1:0] line;
  assign line = code_i - 1'b1;

  always_comb begin
    sel_o = 1'b0;
    for (int g = 0; g < NUM_GEN; g++) begin
      if (gidx_i == GIDX_W'(g) && present_i[g]) begin
        if (code_i == CODE_FALLBACK) sel_o = trg_i[g];
        else if (int'(code_i) <= NUM_SIG) sel_o = bundle[g][line];
      end
    end
  end
endmodule

// File: rtl/evt_sync.sv
module evt_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic in_i,
  output logic out_o
);
  logic ff1_q, ff2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff1_q <= 1'b0;
      ff2_q <= 1'b0;
    end else begin
      ff1_q <= in_i;
      ff2_q <= ff1_q;
    end
  end

  assign out_o = en_i ? ff2_q : in_i;

  p_sync_lat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> out_o == $past(in_i, 2));
endmodule

// File: rtl/evt_stretch.sv
module evt_stretch #(
  parameter int MIN_WIDTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic in_i,
  output logic out_o
);
  localparam int CNT_W = $clog2(MIN_WIDTH) + 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(MIN_WIDTH - 1);

  logic             in_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;

  assign rise = in_i & ~in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      in_q <= in_i;
      if (rise)            cnt_q <= LOAD;
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign out_o = en_i ? (in_i | (cnt_q != 0)) : in_i;

  // an edge must still be visible one cycle later while stretching
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && in_i && !in_q) |=> (!en_i || out_o));
endmodule

// File: rtl/pwm_evt_cond.sv
module pwm_evt_cond import pwm_evt_pkg::*; #(
  parameter int NUM_GEN   = 8,
  parameter int NUM_SIG   = 9,
  parameter int MIN_WIDTH = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cfg_we_i,
  input  logic [CFG_W-1:0]           cfg_wdata_i,
  input  logic [NUM_GEN*NUM_SIG-1:0] gen_sig_i,
  input  logic [NUM_GEN-1:0]         gen_present_i,
  input  logic [NUM_GEN-1:0]         gen_trg_i,
  output logic                       evt_o,
  output logic                       pin_o
);
  evt_cfg_t cfg_q;
  logic     sel_sig, sync_sig, evt;
  logic     unused_cfg_bits;

  assign unused_cfg_bits = ^{cfg_wdata_i[11:8], cfg_wdata_i[3]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (cfg_we_i) begin
      cfg_q.oen   <= cfg_wdata_i[B_OEN];
      cfg_q.pol   <= cfg_wdata_i[B_POL];
      cfg_q.nostr <= cfg_wdata_i[B_NOSTR];
      cfg_q.sync  <= cfg_wdata_i[B_SYNC];
      cfg_q.code  <= cfg_wdata_i[CODE_LSB +: CODE_W];
      cfg_q.gidx  <= cfg_wdata_i[GIDX_LSB +: GIDX_W];
    end
  end

  evt_select #(.NUM_GEN(NUM_GEN), .NUM_SIG(NUM_SIG)) u_select (
    .sig_i     (gen_sig_i),
    .present_i (gen_present_i),
    .trg_i     (gen_trg_i),
    .gidx_i    (cfg_q.gidx),
    .code_i    (cfg_q.code),
    .sel_o     (sel_sig)
  );

  evt_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg_q.sync),
    .in_i   (sel_sig),
    .out_o  (sync_sig)
  );

  evt_stretch #(.MIN_WIDTH(MIN_WIDTH)) u_stretch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (!cfg_q.nostr),
    .in_i   (sync_sig),
    .out_o  (evt)
  );

  assign evt_o = evt;
  assign pin_o = cfg_q.oen ? (evt ^ cfg_q.pol) : cfg_q.pol;

  p_rsv_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cfg_q.code) > NUM_SIG) |-> !sel_sig);

  p_absent_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cfg_q.gidx) < NUM_GEN && !gen_present_i[cfg_q.gidx]) |-> !sel_sig);

  p_direct_path_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.nostr && !cfg_q.sync) |-> evt_o == sel_sig);

  p_pin_pol_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.oen |-> ((pin_o ^ evt_o) == cfg_q.pol));
endmodule

// File: tb/tb_pwm_evt_cond.sv
`timescale 1ns/1ps
module tb_pwm_evt_cond;
  localparam int NG = 8;
  localparam int NS = 9;
  localparam int MW = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cfg_we_i = 1'b0;
  logic [15:0]       cfg_wdata_i = '0;
  logic [NG*NS-1:0]  gen_sig_i = '0;
  logic [NG-1:0]     gen_present_i = '0;
  logic [NG-1:0]     gen_trg_i = '0;
  logic              evt_o, pin_o;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [15:0] m_cfg = '0;
  logic        h1 = 1'b0, h2 = 1'b0, prev_post = 1'b0;
  int          since = MW;

  always #5 clk = ~clk;

  pwm_evt_cond #(.NUM_GEN(NG), .NUM_SIG(NS), .MIN_WIDTH(MW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .gen_sig_i(gen_sig_i), .gen_present_i(gen_present_i), .gen_trg_i(gen_trg_i),
    .evt_o(evt_o), .pin_o(pin_o)
  );

  function automatic logic msel(logic [15:0] c);
    int g = int'(c[2:0]);
    int code = int'(c[7:4]);
    if (!gen_present_i[g]) return 1'b0;        // R5
    if (code == 0) return gen_trg_i[g];         // R2
    if (code <= NS) return gen_sig_i[g*NS + code - 1]; // R3
    return 1'b0;                                // R4
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: inputs already driven after a negedge
  task automatic cyc();
    logic sel_now, post, rise, e_evt, e_pin;
    int   sn, code;
    string t_evt, t_pin;
    #1;
    sel_now = msel(m_cfg);
    post    = m_cfg[12] ? h2 : sel_now;
    rise    = post & ~prev_post;
    sn      = rise ? 0 : since;
    e_evt   = m_cfg[13] ? post : (post | (sn < MW));
    e_pin   = m_cfg[15] ? (e_evt ^ m_cfg[14]) : m_cfg[14];
    code    = int'(m_cfg[7:4]);
    t_evt = (!gen_present_i[m_cfg[2:0]]) ? "R5" : (code > NS) ? "R4" : (code == 0) ? "R2" : "R3";
    t_evt = {t_evt, m_cfg[12] ? " R6" : " R7", m_cfg[13] ? " R9" : " R8"};
    t_pin = m_cfg[15] ? "R10" : "R11";
    chk(t_evt, evt_o, e_evt);
    chk(t_pin, pin_o, e_pin);
    h2 = h1; h1 = sel_now; prev_post = post;
    since = (sn < MW) ? sn + 1 : MW;
    if (cfg_we_i) m_cfg = cfg_wdata_i;
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    cfg_we_i = 1'b1; cfg_wdata_i = d;
    cyc();
    cfg_we_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R1 reset state
    repeat (3) begin
      @(negedge clk);
      chk("R1", evt_o, 1'b0);
      chk("R1", pin_o, 1'b0);
    end
    rst_ni = 1'b1;
    #1;
    chk("R1", evt_o, 1'b0);
    chk("R1", pin_o, 1'b0);
    @(negedge clk);
    gen_present_i = '1;

    // R12: reserved code first, then gen 0 line 0 direct, pin on
    wr(16'h00F0);
    gen_sig_i[0] = 1'b1;
    cfg_we_i = 1'b1; cfg_wdata_i = 16'hA010;
    #1 chk("R12", evt_o, 1'b0);
    cyc();
    cfg_we_i = 1'b0;
    #1 chk("R12", evt_o, 1'b1);
    cyc();
    gen_sig_i = '0;
    cyc();

    // R8 single-cycle pulse then retrigger inside the stretch
    wr(16'h8012);
    repeat (3) cyc();
    gen_sig_i[2*NS] = 1'b1; cyc();
    gen_sig_i = '0; repeat (4) cyc();
    gen_sig_i[2*NS] = 1'b1; cyc();
    gen_sig_i = '0; repeat (12) cyc();
    // R8 long high input, R6 with stretch
    wr(16'h9012);
    gen_sig_i[2*NS] = 1'b1; repeat (12) cyc();
    gen_sig_i = '0; repeat (12) cyc();
    // R11 pin off, active-low polarity; R2 fallback
    wr(16'h6003);
    gen_trg_i[3] = 1'b1; repeat (3) cyc();
    gen_trg_i = '0; repeat (3) cyc();
    // R5 absent generator
    wr(16'hE095);
    gen_present_i[5] = 1'b0; gen_sig_i = '1; repeat (4) cyc();
    gen_present_i = '1; repeat (2) cyc();
    gen_sig_i = '0;

    // random phase
    for (int n = 0; n < 20000; n++) begin
      for (int b = 0; b < NG*NS; b++) gen_sig_i[b] = ($urandom % 4) == 0;
      for (int g = 0; g < NG; g++) begin
        gen_trg_i[g]     = ($urandom % 4) == 0;
        gen_present_i[g] = ($urandom % 8) != 0;
      end
      cfg_we_i    = ($urandom % 24) == 0;
      cfg_wdata_i = 16'($urandom);
      cyc();
    end
    cfg_we_i = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule